// File: doc/BRIEF.md
# Alarm and Clock-Output Interrupt Controller

This block sits beside the time-of-day counters of a real-time clock and drives a single active-low interrupt line from two sources. The first source is an alarm: three latches hold a seconds, minutes and hours target. On each seconds tick the latches are compared with the running counters, and a match raises the interrupt. The second source is a square-wave clock output. The host picks one of fifteen divider taps from the counter chain, and the first falling edge of the chosen wave after it is picked also raises the interrupt.

The host writes one control byte at address 7. Bit 2 of that byte enables the alarm. While bit 2 is set, writes to the seconds, minutes and hours addresses load the alarm latches and do not reach the counters. Bits 7:4 select the clock-out rate, and a value of zero turns the clock output off. A two-bit status register shows which source fired, and reading it releases the line.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset, irq_n is 1, stat is 2'b00, clk_out is 1 and cnt_wr is 0.
- R2: A write to address 7 loads the control byte: bit 2 is the alarm enable and bits 7:4 are the clock-out select. A control write never asserts cnt_wr.
- R3: When the alarm is enabled, a write to address 0 (seconds), 1 (minutes) or 2 (hours) loads the matching alarm latch, and cnt_wr stays 0. When the alarm is disabled, the same write asserts cnt_wr in the same cycle. Writes to addresses 3 to 6 always assert cnt_wr.
- R4: In a cycle where sec_tick is 1 and the alarm is enabled, if all three counters equal their latches, stat bit 0 is set at that clock edge. A mismatch in any one field sets nothing.
- R5: The alarm is tested only when sec_tick is 1. A match that persists with no tick raises no further interrupt after a clear.
- R6: With the alarm disabled, a matching tick leaves stat bit 0 clear.
- R7: clk_out equals div_taps[sel-1] for a select value sel from 1 to 15. When the select is 0, clk_out is held at 1.
- R8: The first falling edge of the selected tap after a control write with a nonzero select sets stat bit 1. Later falling edges set nothing until the control byte is written again.
- R9: A cycle with rd_stat high clears both stat bits at that edge. An event in the same cycle still sets its bit.
- R10: irq_n is 0 exactly when some stat bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_stat | input | 1 | Status read strobe; clears the status register |
| sec_tick | input | 1 | One-cycle pulse in the cycle where the counters show a new second |
| cnt_sec | input | 8 | Running seconds counter |
| cnt_min | input | 8 | Running minutes counter |
| cnt_hr | input | 8 | Running hours counter |
| div_taps | input | 15 | Square-wave taps from the divider chain |
| cnt_wr | output | 1 | Write strobe passed on to the time counters |
| clk_out | output | 1 | Selected clock output |
| irq_n | output | 1 | Active-low interrupt |
| stat | output | 2 | Status: bit 0 is the alarm, bit 1 is the clock output |

## Verification
A wrong latch value or a wrong enable bit shows at the ports on the next seconds tick. stat and irq_n either stay idle on a match, or fall on a mismatch, one cycle after the tick. A stuck arm flag shows on the tap edge after the first one, as a second clock-out interrupt that should not occur, or on the first edge, as a missing one. A wrong select shows at once on clk_out.

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int TW = 8,
  parameter int NTAP = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [7:0]      wr_data,
  input  logic            rd_stat,
  input  logic            sec_tick,
  input  logic [TW-1:0]   cnt_sec,
  input  logic [TW-1:0]   cnt_min,
  input  logic [TW-1:0]   cnt_hr,
  input  logic [NTAP-1:0] div_taps,
  output logic            cnt_wr,
  output logic            clk_out,
  output logic            irq_n,
  output logic [1:0]      stat
);
  localparam logic [2:0] CTRL_ADDR = 3'd7;

  logic [7:0]      ctrl;
  logic [TW-1:0]   al_sec, al_min, al_hr;
  logic [NTAP-1:0] prev_taps;
  logic            armed;

  logic       alarm_en, ctrl_wr, latch_wr, al_hit, fall, ck_hit;
  logic [3:0] sel, idx;

  assign alarm_en = ctrl[2];
  assign sel      = ctrl[7:4];
  assign idx      = sel - 4'd1;
  assign ctrl_wr  = wr_en && wr_addr == CTRL_ADDR;
  assign latch_wr = wr_en && wr_addr <= 3'd2 && alarm_en;
  assign cnt_wr   = wr_en && !ctrl_wr && !latch_wr;

  assign clk_out = (sel == 4'd0) ? 1'b1 : div_taps[idx];
  assign fall    = sel != 4'd0 && prev_taps[idx] && !div_taps[idx];
  assign ck_hit  = armed && fall && !ctrl_wr;
  assign al_hit  = sec_tick && alarm_en &&
                   cnt_sec == al_sec && cnt_min == al_min && cnt_hr == al_hr;
  assign irq_n   = ~|stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl      <= '0;
      al_sec    <= '0;
      al_min    <= '0;
      al_hr     <= '0;
      prev_taps <= '0;
      armed     <= 1'b0;
      stat      <= '0;
    end else begin
      prev_taps <= div_taps;
      if (ctrl_wr) begin
        ctrl  <= wr_data;
        armed <= wr_data[7:4] != 4'd0;
      end else if (ck_hit) begin
        armed <= 1'b0;
      end
      if (latch_wr) begin
        case (wr_addr)
          3'd0:    al_sec <= wr_data[TW-1:0];
          3'd1:    al_min <= wr_data[TW-1:0];
          default: al_hr  <= wr_data[TW-1:0];
        endcase
      end
      stat[0] <= (stat[0] && !rd_stat) || al_hit;
      stat[1] <= (stat[1] && !rd_stat) || ck_hit;
    end
  end
endmodule

module rtc_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic       rd_stat,
  input logic       sec_tick,
  input logic       cnt_wr,
  input logic       clk_out,
  input logic       irq_n,
  input logic [1:0] stat,
  input logic       alarm_en,
  input logic       armed,
  input logic [3:0] sel
);
  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |-> irq_n && stat == 2'b00);
  a_r2_ctrl_no_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr == 3'd7 |-> !cnt_wr);
  a_r3_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_addr <= 3'd2 && alarm_en |-> !cnt_wr);
  a_r5_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> !$rose(stat[0]));
  a_r6_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_en |=> !$rose(stat[0]));
  a_r7_off_high: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 4'd0 |-> clk_out);
  a_r8_once_armed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !$rose(stat[1]));
  a_r9_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat && !sec_tick |=> !stat[0]);
  a_r10_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    stat != 2'b00 |-> !irq_n);
endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk u_chk (.*);

// File: tb/tb_rtc_irq_ctrl.sv
module tb_rtc_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_stat = 1'b0, sec_tick = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0, cnt_sec = '0, cnt_min = '0, cnt_hr = '0;
  logic [14:0] div_taps = '0;
  logic        cnt_wr, clk_out, irq_n;
  logic [1:0]  stat;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_irq_ctrl dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(); rd_stat = 1'b1; step(); rd_stat = 1'b0; endtask

  task automatic tick(); sec_tick = 1'b1; step(); sec_tick = 1'b0; endtask

  task automatic t_reset();
    chk("R1 irq_n", irq_n, 1);
    chk("R1 stat", stat, 0);
    chk("R1 clk_out", clk_out, 1);
    chk("R1 cnt_wr", cnt_wr, 0);
  endtask

  task automatic t_redirect();
    wr_en = 1'b1; wr_addr = 3'd7; wr_data = 8'h00; #1;
    chk("R2 ctrl write no cnt_wr", cnt_wr, 0);
    step();
    wr_addr = 3'd0; #1;
    chk("R3 alarm off passes write", cnt_wr, 1);
    step(); wr_en = 1'b0;
    wr(3'd7, 8'h04);
    wr_en = 1'b1; wr_addr = 3'd1; #1;
    chk("R3 alarm on blocks write", cnt_wr, 0);
    wr_addr = 3'd4; #1;
    chk("R3 addr 4 always passes", cnt_wr, 1);
    step(); wr_en = 1'b0;
  endtask

  task automatic t_alarm();
    wr(3'd7, 8'h04);
    wr(3'd0, 8'h05); wr(3'd1, 8'h06); wr(3'd2, 8'h07);
    cnt_sec = 8'h05; cnt_min = 8'h06; cnt_hr = 8'h07;
    step(); step();
    chk("R5 no tick no irq", irq_n, 1);
    tick();
    chk("R4 match sets alarm bit", stat, 2'b01);
    chk("R10 irq low", irq_n, 0);
    rd();
    chk("R9 read clears", stat, 2'b00);
    chk("R10 irq released", irq_n, 1);
    step(); step();
    chk("R5 persisting match no re-raise", stat, 2'b00);
    cnt_min = 8'h09;
    tick();
    chk("R4 minutes mismatch", stat, 2'b00);
    cnt_min = 8'h06;
    rd_stat = 1'b1; tick(); rd_stat = 1'b0;
    chk("R9 event beats read", stat, 2'b01);
    rd();
  endtask

  task automatic t_disabled();
    wr(3'd7, 8'h00);
    tick();
    chk("R6 disabled no alarm", stat, 2'b00);
    chk("R6 irq idle", irq_n, 1);
  endtask

  task automatic t_clkout();
    div_taps = '0;
    wr(3'd7, 8'h30);
    chk("R7 sel3 low", clk_out, 0);
    div_taps[2] = 1'b1; #1;
    chk("R7 sel3 follows tap2", clk_out, 1);
    step();
    div_taps[2] = 1'b0; step();
    chk("R8 first fall sets bit1", stat, 2'b10);
    chk("R10 irq low on clkout", irq_n, 0);
    rd();
    div_taps[2] = 1'b1; step();
    div_taps[2] = 1'b0; step();
    chk("R8 second fall ignored", stat, 2'b00);
    div_taps[0] = 1'b1; #1;
    chk("R7 other tap ignored", clk_out, 0);
    wr(3'd7, 8'hF0);
    div_taps[14] = 1'b1; #1;
    chk("R7 sel15 follows tap14", clk_out, 1);
    step();
    div_taps[14] = 1'b0; step();
    chk("R8 rearmed by ctrl write", stat, 2'b10);
    rd();
    wr(3'd7, 8'h00);
    chk("R7 off drives high", clk_out, 1);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    step(); step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_redirect();
    t_alarm();
    t_disabled();
    t_clkout();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule